// File: doc/BRIEF.md
# Transmit Encoder Handshake Status

This block sits between a host and the shift engine of a serial word encoder. The host writes 16-bit words into an encoder data register. Each word waits in a one-word pending buffer until the transmit engine can take it, and is then handed over with a one-cycle load pulse. The engine signals the end of every word with a done pulse. If a word is pending at that moment, it goes out next without a gap. If no word is pending, the engine stops.

A 16-bit status word, active low throughout, reports three things to the host:
- whether the buffer can take another word;
- whether all transmission has ended with nothing left to send;
- whether a failsafe timeout has been seen since the last received message.

Writes made while the buffer is still full are dropped and recorded in a sticky flag. A cycle counter measures how long the buffer stays empty while a word is on the line. This catches hosts that miss the back-to-back loading window, whose length is `CLK_MHZ * WINDOW_US` cycles.

Top module: `txenc_handshake`

## Requirements
- R1: While reset is asserted, and after its release until the first stimulus, the status word reads 16'h7F7F and the load pulse is 0.
- R2: Status bit 15 (ready, active low) reads 1 while a word waits in the pending buffer and 0 when the buffer is empty.
- R3: A host write made while bit 15 is 0 is accepted. When the engine is idle, the word appears on the transmit word output, with the load pulse high, two cycles after the write.
- R4: When the engine finishes a word while another is pending, the pending word is handed over with the load pulse in the cycle after the done pulse.
- R5: A host write made while bit 15 is 1 is dropped and leaves the pending word unchanged. Bit 8 then reads 0 from the next cycle and stays 0 until reset.
- R6: Status bit 7 (end of transmission, active low) reads 0 exactly when the engine is idle and no word is pending. A done pulse with no word pending stops the engine, and bit 7 reads 0 in the next cycle.
- R7: Status bit 0 (failsafe, active low) goes to 0 the cycle after a timeout pulse and to 1 the cycle after a new-message pulse. When both pulses arrive together, the timeout wins. Reset sets bit 0 to 1.
- R8: Status bit 6 (late load, active low) goes to 0 once the buffer has stayed empty for `CLK_MHZ*WINDOW_US` consecutive cycles while the engine is transmitting. A load made before then keeps it at 1. Once 0, it stays 0 until reset.
- R9: Status bits 14 to 9 and 5 to 1 always read 1.
- R10: A done pulse while the engine is idle has no effect: there is no load pulse, bit 7 stays 0 and the transmit word output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe for the encoder data register |
| host_data | input | DATA_W | Word written by the host |
| word_done | input | 1 | Pulse from the transmit engine at the end of a word |
| new_msg | input | 1 | Pulse when a new message has been received |
| fs_timeout | input | 1 | Pulse when a failsafe timeout occurs |
| status | output | 16 | Active-low encoder status word |
| tx_load | output | 1 | One-cycle pulse handing a word to the engine |
| tx_word | output | DATA_W | Word handed to the engine |

## Verification
The handshake is tried with several loading patterns:
- a write into an idle encoder, which separates the pending state from the handoff;
- a second write while a word is on the line, which shows the back-to-back path through the done pulse;
- a third write into a full buffer, which must be dropped without disturbing the pending word;
- done pulses with nothing pending and while idle, which separate stopping from ignoring.

The loading window is probed one cycle short of expiry and again at exact expiry, so an off-by-one in the counter shows. The failsafe flag is driven through timeout-only, message-only, idle and simultaneous pulses to pin down which event takes priority.

// File: rtl/txenc_hs_pkg.sv
package txenc_hs_pkg;

  localparam int STAT_W     = 16;
  localparam int BIT_READY  = 15;
  localparam int BIT_IGNWR  = 8;
  localparam int BIT_DONE   = 7;
  localparam int BIT_LATE   = 6;
  localparam int BIT_FSAFE  = 0;

  typedef struct packed {
    logic ready_n;
    logic ignwr_n;
    logic done_n;
    logic late_n;
    logic fsafe_n;
  } hs_flags_t;

  function automatic logic [STAT_W-1:0] pack_status(hs_flags_t f);
    logic [STAT_W-1:0] s;
    s            = '1;
    s[BIT_READY] = f.ready_n;
    s[BIT_IGNWR] = f.ignwr_n;
    s[BIT_DONE]  = f.done_n;
    s[BIT_LATE]  = f.late_n;
    s[BIT_FSAFE] = f.fsafe_n;
    return s;
  endfunction

endpackage

// File: rtl/txenc_hs_buffer.sv
module txenc_hs_buffer #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              word_done_i,
  output logic              pend_o,
  output logic              active_o,
  output logic              drop_o,
  output logic              load_o,
  output logic [DATA_W-1:0] word_o
);

  logic              pend_q, pend_d;
  logic [DATA_W-1:0] pdata_q, pdata_d;
  logic              active_q, active_d;
  logic              load_q, load_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              accept, handoff;

  always_comb begin
    accept   = wr_i & ~pend_q;
    handoff  = pend_q & (~active_q | word_done_i);
    pend_d   = pend_q;
    pdata_d  = pdata_q;
    active_d = active_q;
    word_d   = word_q;
    load_d   = handoff;
    if (accept) begin
      pend_d  = 1'b1;
      pdata_d = wr_data_i;
    end
    if (handoff) begin
      pend_d   = 1'b0;
      active_d = 1'b1;
      word_d   = pdata_q;
    end else if (active_q && word_done_i) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pdata_q  <= '0;
      active_q <= 1'b0;
      load_q   <= 1'b0;
      word_q   <= '0;
    end else begin
      pend_q   <= pend_d;
      active_q <= active_d;
      load_q   <= load_d;
      if (accept)  pdata_q <= pdata_d;
      if (handoff) word_q  <= word_d;
    end
  end

  assign pend_o   = pend_q;
  assign active_o = active_q;
  assign drop_o   = wr_i & pend_q;
  assign load_o   = load_q;
  assign word_o   = word_q;

endmodule

// File: rtl/txenc_hs_window.sv
module txenc_hs_window #(
  parameter int WIN_CYC = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);

  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] FULL = CW'(WIN_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = run_i ? (cnt_q != FULL) : (cnt_q != '0);
    cnt_d  = run_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = run_i & (cnt_q == LAST);

endmodule

// File: rtl/txenc_hs_flags.sv
module txenc_hs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_timeout_i,
  input  logic new_msg_i,
  input  logic drop_i,
  input  logic expire_i,
  output logic fsafe_n_o,
  output logic ignwr_n_o,
  output logic late_n_o
);

  logic fsafe_q, fsafe_d;
  logic ign_q, ign_d;
  logic late_q, late_d;

  always_comb begin
    fsafe_d = fsafe_q;
    if (new_msg_i)    fsafe_d = 1'b1;
    if (fs_timeout_i) fsafe_d = 1'b0;
    ign_d  = ign_q  & ~drop_i;
    late_d = late_q & ~expire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsafe_q <= 1'b1;
      ign_q   <= 1'b1;
      late_q  <= 1'b1;
    end else begin
      fsafe_q <= fsafe_d;
      ign_q   <= ign_d;
      late_q  <= late_d;
    end
  end

  assign fsafe_n_o = fsafe_q;
  assign ignwr_n_o = ign_q;
  assign late_n_o  = late_q;

endmodule

// File: rtl/txenc_handshake.sv
module txenc_handshake
  import txenc_hs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CLK_MHZ   = 2,
  parameter int WINDOW_US = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              word_done,
  input  logic              new_msg,
  input  logic              fs_timeout,
  output logic [STAT_W-1:0] status,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_word
);

  localparam int WIN_CYC = CLK_MHZ * WINDOW_US;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic pend, active, drop, expire;
  logic fsafe_n, ignwr_n, late_n;
  hs_flags_t flags;

  txenc_hs_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_i       (host_wr),
    .wr_data_i  (host_data),
    .word_done_i(word_done),
    .pend_o     (pend),
    .active_o   (active),
    .drop_o     (drop),
    .load_o     (tx_load),
    .word_o     (tx_word)
  );

  txenc_hs_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_i   (active & ~pend),
    .expire_o(expire)
  );

  txenc_hs_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fs_timeout_i(fs_timeout),
    .new_msg_i   (new_msg),
    .drop_i      (drop),
    .expire_i    (expire),
    .fsafe_n_o   (fsafe_n),
    .ignwr_n_o   (ignwr_n),
    .late_n_o    (late_n)
  );

  always_comb begin
    flags.ready_n = pend;
    flags.done_n  = active | pend;
    flags.ignwr_n = ignwr_n;
    flags.late_n  = late_n;
    flags.fsafe_n = fsafe_n;
    status        = pack_status(flags);
  end

endmodule

// File: rtl/txenc_handshake_chk.sv
module txenc_handshake_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        host_wr,
  input logic        word_done,
  input logic        new_msg,
  input logic        fs_timeout,
  input logic [15:0] status,
  input logic        tx_load
);

  a_r3_accept_fills: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_wr && !status[15] |=> status[15]);

  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_sync_n)
    word_done && status[15] |=> tx_load);

  a_r5_drop_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_wr && status[15] |=> !status[8]);

  a_r5_drop_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !status[8] |=> !status[8]);

  a_r6_end_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !status[7] |-> !status[15]);

  a_r6_stop_no_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    word_done && !status[15] |=> !tx_load);

  a_r7_timeout_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fs_timeout |=> !status[0]);

  a_r7_message_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    new_msg && !fs_timeout |=> status[0]);

  a_r8_late_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !status[6] |=> !status[6]);

  a_r10_idle_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    word_done && !status[7] && !host_wr |=> !status[7] && !tx_load);

endmodule

bind txenc_handshake txenc_handshake_chk i_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .host_wr   (host_wr),
  .word_done (word_done),
  .new_msg   (new_msg),
  .fs_timeout(fs_timeout),
  .status    (status),
  .tx_load   (tx_load)
);

// File: tb/test_txenc_handshake.sv
module test_txenc_handshake;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 2;
  localparam int WINDOW_US  = 18;
  localparam int WIN        = CLK_MHZ * WINDOW_US;
  localparam logic [15:0] UNUSED_MASK = 16'h7E3E;

  // failsafe vectors: {fs_timeout, new_msg, expected bit 0}
  localparam int NV = 7;
  localparam logic [2:0] FS_VEC [NV] = '{
    3'b100, 3'b000, 3'b011, 3'b001, 3'b110, 3'b011, 3'b100
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [15:0] host_data;
  logic        word_done;
  logic        new_msg;
  logic        fs_timeout;
  logic [15:0] status;
  logic        tx_load;
  logic [15:0] tx_word;

  int checks = 0;
  int fails  = 0;

  txenc_handshake #(.DATA_W(16), .CLK_MHZ(CLK_MHZ), .WINDOW_US(WINDOW_US)) i_txenc_handshake (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_data (host_data),
    .word_done (word_done),
    .new_msg   (new_msg),
    .fs_timeout(fs_timeout),
    .status    (status),
    .tx_load   (tx_load),
    .tx_word   (tx_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_data = '0; word_done = 1'b0;
    new_msg = 1'b0; fs_timeout = 1'b0;
    tick(); tick();
    check("R1 reset status", status, 16'h7F7F);
    check("R1 reset load", {15'd0, tx_load}, 16'd0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R1 status after release", status, 16'h7F7F);
    check("R9 unused bits", status & UNUSED_MASK, UNUSED_MASK);

    // R3: write into idle encoder
    host_wr = 1'b1; host_data = 16'hA5A5;
    tick();
    host_wr = 1'b0;
    check("R2 ready bit with word pending", {15'd0, status[15]}, 16'd1);
    check("R6 end bit with word pending", {15'd0, status[7]}, 16'd1);
    tick();
    check("R3 load pulse", {15'd0, tx_load}, 16'd1);
    check("R3 word out", tx_word, 16'hA5A5);
    check("R2 ready after handoff", {15'd0, status[15]}, 16'd0);

    // R4/R5: next word, then a dropped write
    host_wr = 1'b1; host_data = 16'h1234;
    tick();
    check("R2 ready while second word pending", {15'd0, status[15]}, 16'd1);
    check("R3 no load while active", {15'd0, tx_load}, 16'd0);
    host_data = 16'hDEAD;
    tick();
    host_wr = 1'b0;
    check("R5 dropped write flag", {15'd0, status[8]}, 16'd0);
    word_done = 1'b1;
    tick();
    word_done = 1'b0;
    check("R4 contiguous load", {15'd0, tx_load}, 16'd1);
    check("R5 pending word kept", tx_word, 16'h1234);

    // R6: stop with nothing pending
    word_done = 1'b1;
    tick();
    check("R6 end of transmission", {15'd0, status[7]}, 16'd0);
    check("R6 no load on stop", {15'd0, tx_load}, 16'd0);
    // R10: done while idle
    tick();
    word_done = 1'b0;
    check("R10 idle done no load", {15'd0, tx_load}, 16'd0);
    check("R10 idle end bit", {15'd0, status[7]}, 16'd0);
    check("R10 word unchanged", tx_word, 16'h1234);
    check("R5 dropped flag sticky", {15'd0, status[8]}, 16'd0);

    // R8: loading window
    host_wr = 1'b1; host_data = 16'h0F0F;
    tick();
    host_wr = 1'b0;
    tick();
    check("R3 window word out", tx_word, 16'h0F0F);
    repeat (WIN - 2) tick();
    check("R8 late bit before window", {15'd0, status[6]}, 16'd1);
    host_wr = 1'b1; host_data = 16'h3C3C;
    tick();
    host_wr = 1'b0;
    check("R8 late bit after timely load", {15'd0, status[6]}, 16'd1);
    word_done = 1'b1;
    tick();
    word_done = 1'b0;
    check("R4 window word out", tx_word, 16'h3C3C);
    repeat (WIN - 1) tick();
    check("R8 late bit one short", {15'd0, status[6]}, 16'd1);
    tick();
    check("R8 late bit at expiry", {15'd0, status[6]}, 16'd0);
    word_done = 1'b1;
    tick();
    word_done = 1'b0;
    tick();
    check("R8 late bit sticky", {15'd0, status[6]}, 16'd0);
    check("R6 end after drain", {15'd0, status[7]}, 16'd0);
    check("R9 unused bits mid-run", status & UNUSED_MASK, UNUSED_MASK);

    // R7: failsafe vectors
    for (int i = 0; i < NV; i++) begin
      fs_timeout = FS_VEC[i][2];
      new_msg    = FS_VEC[i][1];
      tick();
      fs_timeout = 1'b0;
      new_msg    = 1'b0;
      check($sformatf("R7 failsafe vector %0d", i), {15'd0, status[0]}, {15'd0, FS_VEC[i][0]});
    end

    // R1/R7: reset restores everything
    rst_n = 1'b0;
    tick();
    check("R7 reset sets failsafe and R1 status", status, 16'h7F7F);
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R1 status after second release", status, 16'h7F7F);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule